// File: doc/BRIEF.md
# Accumulator Machine Step Controller

This block is the sequencing controller for a small accumulator computer that moves all data over one shared bus. It takes the opcode held in the instruction register and a flag saying whether the accumulator is zero. Every clock it drives a set of control strobes that tell the datapath which source drives the bus and which registers capture it. The program counter, address register, buffer register, accumulator, memory and I/O port all sit outside the block.

Each instruction starts with a two-step fetch. The controller then walks the steps for that opcode. Arithmetic always goes through the buffer register and an adder: the buffer is loaded with zero for a load, input or clear, and with the accumulator for an add or subtract. The accumulator then takes buffer plus bus, or buffer minus bus.

An operand address is reached in two steps: first the address register takes the program counter, then it takes the memory word found there. The input and halt opcodes assert a clock-hold strobe. While that strobe is high, the datapath clock is stopped and the controller holds its state. On the edge where the user raises `run`, the strobes shown take effect and execution moves on.

Top module: `accm_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller enters the first fetch step. In that step only `pc_drive` and `addr_load` are high.
- R2: Every instruction starts with two fetch steps. The first has `pc_drive` and `addr_load`. The second has `mem_drive`, `instr_load` and `pc_step`, so the program counter is past the opcode word before any execution step.
- R3: Opcodes are load=0, add=1, subtract=2, store=3, jump-if-zero=4, input=5, clear=6, halt=7. For load, add and subtract, the step after fetch loads the buffer register, from constant 0 for load or from the accumulator for add and subtract. The final step loads the accumulator with buffer plus the memory operand. Each takes 6 clocks including fetch.
- R4: Subtract raises `sub_mode` only in its final accumulator-load step, so the accumulator becomes buffer minus bus, modulo 2^width.
- R5: Opcodes 0 to 4 are followed by one operand word. The address register is first loaded from the program counter while `pc_step` is high, then loaded from memory. Execution then resumes at the word after the operand.
- R6: Store takes 5 clocks. After the two address steps, `acc_drive` and `mem_write` are high together, which writes the accumulator to the operand address.
- R7: Jump-if-zero takes 4 clocks. Its first step loads the address register from the program counter and steps the program counter. Its second step drives memory onto the bus and raises `pc_load` only when `acc_is_zero` is high.
- R8: Input takes 4 clocks. Its second step raises `clk_hold`, `port_drive` and `acc_load`, and holds them until `run` is sampled high. The accumulator then takes 0 plus the port value, and fetch follows.
- R9: Clear takes 4 clocks. It loads the buffer from constant 0, then loads the accumulator with 0 plus constant 0.
- R10: Halt raises `clk_hold` in the step after fetch and holds it until `run` is sampled high. Execution then continues with the next instruction word.
- R11: In every cycle at most one of `acc_drive`, `const_drive`, `pc_drive`, `mem_drive` and `port_drive` is high.
- R12: While `clk_hold` is low, `run` has no effect on the step sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | User resume while the clock is held |
| opcode | input | 3 | Opcode from the instruction register |
| acc_is_zero | input | 1 | Accumulator equals zero |
| buf_load | output | 1 | Buffer register captures the bus |
| sub_mode | output | 1 | Adder subtracts the bus from the buffer |
| acc_load | output | 1 | Accumulator captures the adder result |
| acc_drive | output | 1 | Accumulator drives the bus |
| const_drive | output | 1 | Constant drives the bus |
| const_one | output | 1 | Constant select (0 or 1); this set uses 0 |
| pc_drive | output | 1 | Program counter drives the bus |
| pc_load | output | 1 | Program counter captures the bus |
| pc_step | output | 1 | Program counter increments |
| mem_write | output | 1 | Memory writes the bus at the address register |
| port_drive | output | 1 | I/O port drives the bus |
| mem_drive | output | 1 | Memory drives the bus |
| addr_load | output | 1 | Address register captures the bus |
| instr_load | output | 1 | Instruction register captures the bus |
| clk_hold | output | 1 | Datapath clock stopped until `run` |

## Verification
The bench surrounds the controller with a model datapath. It compares accumulator, memory, final program counter and clock counts against an instruction-level reference, over directed programs and seeded random ones.

It targets four corner cases:
- A taken jump and a not-taken jump. A controller that steps the program counter in the wrong step would land mid-operand and run the wrong code.
- Subtraction that wraps below zero. A missing or misplaced `sub_mode` would yield a sum.
- Input and mid-program halt stalls of varied length, with `run` pulses also thrown in while the clock is free. A controller that leaves the stall early, or reacts to a stray `run`, would misload the accumulator or skip instructions.
- Exact per-instruction clock counts. An extra or missing step shows up as a count mismatch.

// File: rtl/accm_pkg.sv
`timescale 1ns/1ps
package accm_pkg;

  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LDA = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_STA = 3'd3,
    OP_JPZ = 3'd4,
    OP_IN  = 3'd5,
    OP_CLR = 3'd6,
    OP_HLT = 3'd7
  } op_t;

  typedef enum logic [3:0] {
    ST_FETCH_A,
    ST_FETCH_B,
    ST_STEP1,
    ST_OPND_PTR,
    ST_OPND_ADR,
    ST_ALU_LOAD,
    ST_STORE,
    ST_JUMP,
    ST_PORT_LOAD,
    ST_CLR_LOAD
  } st_t;

  // opcode classes
  typedef struct packed {
    logic arith;     // load/add/subtract via buffer+adder
    logic from_acc;  // buffer source is the accumulator
    logic subtract;
    logic store;
    logic branch;
    logic port_in;
    logic clear;
    logic halt;
  } op_cls_t;

  typedef struct packed {
    logic buf_load;
    logic sub_mode;
    logic acc_load;
    logic acc_drive;
    logic const_drive;
    logic const_one;
    logic pc_drive;
    logic pc_load;
    logic pc_step;
    logic mem_write;
    logic port_drive;
    logic mem_drive;
    logic addr_load;
    logic instr_load;
    logic clk_hold;
  } ctl_t;

  function automatic op_cls_t classify(input logic [OPW-1:0] op);
    op_cls_t c;
    c = '0;
    unique case (op)
      OP_LDA:  c.arith = 1'b1;
      OP_ADD:  begin c.arith = 1'b1; c.from_acc = 1'b1; end
      OP_SUB:  begin c.arith = 1'b1; c.from_acc = 1'b1; c.subtract = 1'b1; end
      OP_STA:  c.store = 1'b1;
      OP_JPZ:  c.branch = 1'b1;
      OP_IN:   c.port_in = 1'b1;
      OP_CLR:  c.clear = 1'b1;
      default: c.halt = 1'b1;
    endcase
    return c;
  endfunction

  // bus sources of a strobe set, for the exclusivity rule
  function automatic logic [4:0] bus_sources(input ctl_t c);
    return {c.acc_drive, c.const_drive, c.pc_drive, c.mem_drive, c.port_drive};
  endfunction

endpackage

// File: rtl/accm_opdec.sv
`timescale 1ns/1ps
module accm_opdec
  import accm_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output op_cls_t        cls
);

  always_comb cls = classify(opcode);

endmodule

// File: rtl/accm_seq.sv
`timescale 1ns/1ps
module accm_seq
  import accm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic is_arith,
  input  logic is_store,
  input  logic is_branch,
  input  logic is_port_in,
  input  logic is_clear,
  input  logic is_halt,
  output st_t  state,
  output logic stall,
  output logic instr_end
);

  st_t state_nx;

  // states that wait on the user
  assign stall = (state == ST_PORT_LOAD) || (state == ST_STEP1 && is_halt);

  always_comb begin
    state_nx = ST_FETCH_A;
    unique case (state)
      ST_FETCH_A:  state_nx = ST_FETCH_B;
      ST_FETCH_B:  state_nx = ST_STEP1;
      ST_STEP1: begin
        if (is_arith)        state_nx = ST_OPND_PTR;
        else if (is_store)   state_nx = ST_OPND_ADR;
        else if (is_branch)  state_nx = ST_JUMP;
        else if (is_port_in) state_nx = ST_PORT_LOAD;
        else if (is_clear)   state_nx = ST_CLR_LOAD;
        else                 state_nx = run ? ST_FETCH_A : ST_STEP1;
      end
      ST_OPND_PTR:  state_nx = ST_OPND_ADR;
      ST_OPND_ADR:  state_nx = is_store ? ST_STORE : ST_ALU_LOAD;
      ST_PORT_LOAD: state_nx = run ? ST_FETCH_A : ST_PORT_LOAD;
      default:      state_nx = ST_FETCH_A;
    endcase
  end

  assign instr_end = (state != ST_FETCH_A) && (state_nx == ST_FETCH_A);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH_A;
    else     state <= state_nx;
  end

  // R8 / R10: a stall without run keeps the step
  p_stall_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (stall && !run) |=> (state == $past(state)));

  // R12: outside a stall every step advances, whatever run does
  p_run_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (state != $past(state)));

endmodule

// File: rtl/accm_strobe.sv
`timescale 1ns/1ps
module accm_strobe
  import accm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  st_t     state,
  input  op_cls_t cls,
  input  logic    acc_is_zero,
  output ctl_t    ctl
);

  logic zero_src;   // step 1 of load/input/clear/add/sub goes to buffer
  assign zero_src = cls.arith || cls.port_in || cls.clear;

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_FETCH_A: begin
        ctl.pc_drive  = 1'b1;
        ctl.addr_load = 1'b1;
      end
      ST_FETCH_B: begin
        ctl.mem_drive  = 1'b1;
        ctl.instr_load = 1'b1;
        ctl.pc_step    = 1'b1;
      end
      ST_STEP1: begin
        if (zero_src) begin
          ctl.buf_load    = 1'b1;
          ctl.acc_drive   = cls.from_acc;
          ctl.const_drive = !cls.from_acc;
        end else if (cls.store || cls.branch) begin
          ctl.pc_drive  = 1'b1;
          ctl.addr_load = 1'b1;
          ctl.pc_step   = 1'b1;
        end else begin
          ctl.clk_hold = cls.halt;
        end
      end
      ST_OPND_PTR: begin
        ctl.pc_drive  = 1'b1;
        ctl.addr_load = 1'b1;
        ctl.pc_step   = 1'b1;
      end
      ST_OPND_ADR: begin
        ctl.mem_drive = 1'b1;
        ctl.addr_load = 1'b1;
      end
      ST_ALU_LOAD: begin
        ctl.mem_drive = 1'b1;
        ctl.acc_load  = 1'b1;
        ctl.sub_mode  = cls.subtract;
      end
      ST_STORE: begin
        ctl.acc_drive = 1'b1;
        ctl.mem_write = 1'b1;
      end
      ST_JUMP: begin
        ctl.mem_drive = 1'b1;
        ctl.pc_load   = acc_is_zero;
      end
      ST_PORT_LOAD: begin
        ctl.clk_hold   = 1'b1;
        ctl.port_drive = 1'b1;
        ctl.acc_load   = 1'b1;
      end
      ST_CLR_LOAD: begin
        ctl.const_drive = 1'b1;
        ctl.acc_load    = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  p_one_bus_source_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_sources(ctl)));

  p_jump_needs_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_load |-> acc_is_zero);

  p_sub_in_final_load_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.sub_mode |-> (ctl.acc_load && ctl.mem_drive));

  p_store_drives_acc_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_write |-> (ctl.acc_drive && !ctl.acc_load));

endmodule

// File: rtl/accm_ctrl.sv
`timescale 1ns/1ps
module accm_ctrl
  import accm_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [OPW-1:0] opcode,
  input  logic           acc_is_zero,
  output logic           buf_load,
  output logic           sub_mode,
  output logic           acc_load,
  output logic           acc_drive,
  output logic           const_drive,
  output logic           const_one,
  output logic           pc_drive,
  output logic           pc_load,
  output logic           pc_step,
  output logic           mem_write,
  output logic           port_drive,
  output logic           mem_drive,
  output logic           addr_load,
  output logic           instr_load,
  output logic           clk_hold
);

  op_cls_t cls;
  st_t     state;
  logic    stall;
  logic    instr_end;
  ctl_t    ctl;

  accm_opdec u_dec (
    .opcode (opcode),
    .cls    (cls)
  );

  accm_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .is_arith   (cls.arith),
    .is_store   (cls.store),
    .is_branch  (cls.branch),
    .is_port_in (cls.port_in),
    .is_clear   (cls.clear),
    .is_halt    (cls.halt),
    .state      (state),
    .stall      (stall),
    .instr_end  (instr_end)
  );

  accm_strobe u_stb (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .cls         (cls),
    .acc_is_zero (acc_is_zero),
    .ctl         (ctl)
  );

  assign buf_load    = ctl.buf_load;
  assign sub_mode    = ctl.sub_mode;
  assign acc_load    = ctl.acc_load;
  assign acc_drive   = ctl.acc_drive;
  assign const_drive = ctl.const_drive;
  assign const_one   = ctl.const_one;
  assign pc_drive    = ctl.pc_drive;
  assign pc_load     = ctl.pc_load;
  assign pc_step     = ctl.pc_step;
  assign mem_write   = ctl.mem_write;
  assign port_drive  = ctl.port_drive;
  assign mem_drive   = ctl.mem_drive;
  assign addr_load   = ctl.addr_load;
  assign instr_load  = ctl.instr_load;
  assign clk_hold    = ctl.clk_hold;

  p_reset_to_fetch_r1: assert property (@(posedge clk)
    rst |=> (pc_drive && addr_load && !instr_load && !clk_hold));

  p_fetch_after_instr_r2: assert property (@(posedge clk) disable iff (rst)
    instr_end |=> (pc_drive && addr_load));

  p_opcode_after_addr_r2: assert property (@(posedge clk) disable iff (rst)
    instr_load |-> $past(pc_drive && addr_load));

  p_operand_via_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_load && mem_drive) |-> $past(mem_drive && addr_load));

  p_store_after_addr_r6: assert property (@(posedge clk) disable iff (rst)
    mem_write |-> $past(mem_drive && addr_load));

  p_hold_matches_stall_r10: assert property (@(posedge clk) disable iff (rst)
    clk_hold |-> stall);

  p_hold_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (clk_hold && !run) |=> clk_hold);

endmodule

// File: tb/sim_accm_ctrl.sv
`timescale 1ns/1ps
module sim_accm_ctrl;
  import accm_pkg::*;

  localparam int DW = 8;
  localparam int MEMN = 256;
  localparam int DBASE = 200;
  localparam int NDATA = 16;
  localparam int NIN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [2:0] ir = 3'd0;
  logic zflag;
  logic buf_load, sub_mode, acc_load, acc_drive, const_drive, const_one;
  logic pc_drive, pc_load, pc_step, mem_write, port_drive, mem_drive;
  logic addr_load, instr_load, clk_hold;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  accm_ctrl u0 (
    .clk(clk), .rst(rst), .run(run), .opcode(ir), .acc_is_zero(zflag),
    .buf_load(buf_load), .sub_mode(sub_mode), .acc_load(acc_load),
    .acc_drive(acc_drive), .const_drive(const_drive), .const_one(const_one),
    .pc_drive(pc_drive), .pc_load(pc_load), .pc_step(pc_step),
    .mem_write(mem_write), .port_drive(port_drive), .mem_drive(mem_drive),
    .addr_load(addr_load), .instr_load(instr_load), .clk_hold(clk_hold)
  );

  // ---------------- datapath model ----------------
  logic [DW-1:0] acc = '0, abr = '0, pc = '0, mar = '0, bus;
  logic [DW-1:0] mem [MEMN];
  logic [DW-1:0] img [MEMN];
  logic [DW-1:0] rmem [MEMN];
  logic [DW-1:0] in_vals [NIN];
  int in_idx = 0;
  int applied = 0;
  int conflicts = 0;
  int sub_stray = 0;
  int last_addr = 0;
  bit noise_en = 0;
  int wait_cnt = 0;
  int wait_tgt = 1;

  assign zflag = (acc == '0);

  always_comb begin
    bus = '0;
    if (acc_drive)        bus = acc;
    else if (const_drive) bus = const_one ? DW'(1) : '0;
    else if (pc_drive)    bus = pc;
    else if (mem_drive)   bus = mem[mar];
    else if (port_drive)  bus = in_vals[in_idx % NIN];
  end

  always @(posedge clk) begin
    if (rst) begin
      mem <= img; pc <= '0; acc <= '0; abr <= '0; mar <= '0; ir <= 3'd0;
      in_idx <= 0; applied <= 0;
    end else if (!clk_hold || run) begin
      applied <= applied + 1;
      if (buf_load)  abr <= bus;
      if (acc_load)  acc <= sub_mode ? abr - bus : abr + bus;
      if (acc_load && port_drive) in_idx <= in_idx + 1;
      if (addr_load) mar <= bus;
      if (mem_write) mem[mar] <= bus;
      if (instr_load) ir <= bus[2:0];
      if (pc_load)   pc <= bus;
      else if (pc_step) pc <= pc + 1'b1;
    end
  end

  // bus and strobe discipline monitor (R11, R4)
  always @(negedge clk) begin
    if (!rst) begin
      if ($countones({acc_drive, const_drive, pc_drive, mem_drive, port_drive}) > 1)
        conflicts = conflicts + 1;
      if (sub_mode && !acc_load) sub_stray = sub_stray + 1;
    end
  end

  // user run driver: resumes stalls after a random wait, noise elsewhere
  always @(negedge clk) begin
    if (rst) begin
      run = 1'b0; wait_cnt = 0;
    end else if (clk_hold) begin
      wait_cnt = wait_cnt + 1;
      if (ir == 3'd7 && int'(pc) == last_addr + 1) run = 1'b0;
      else if (wait_cnt >= wait_tgt) begin
        run = 1'b1;
        wait_tgt = 1 + int'($urandom % 4);
      end else run = 1'b0;
    end else begin
      wait_cnt = 0;
      run = noise_en && ($urandom % 3 == 0);
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int op_cycles(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd2: return 6;
      3'd3:             return 5;
      default:          return 4;
    endcase
  endfunction

  // instruction-level reference model
  task automatic ref_run(output logic [DW-1:0] ea, output logic [DW-1:0] epc,
                         output int ecyc);
    logic [DW-1:0] p, a, adr;
    logic [2:0] op;
    int k;
    bit done;
    for (int i = 0; i < MEMN; i++) rmem[i] = img[i];
    p = '0; a = '0; k = 0; ecyc = 0; done = 0;
    for (int n = 0; n < 500 && !done; n++) begin
      op = rmem[p][2:0];
      p = p + 1'b1;
      if (op <= 3'd4) begin adr = rmem[p]; p = p + 1'b1; end
      else adr = '0;
      case (op)
        3'd0: a = rmem[adr];
        3'd1: a = a + rmem[adr];
        3'd2: a = a - rmem[adr];
        3'd3: rmem[adr] = a;
        3'd4: if (a == '0) p = adr;
        3'd5: begin a = in_vals[k % NIN]; k++; end
        3'd6: a = '0;
        default: ;
      endcase
      if (op == 3'd7) begin
        if (int'(p) - 1 == last_addr) begin done = 1; ecyc += 2; end
        else ecyc += 3;
      end else ecyc += op_cycles(op);
    end
    ea = a; epc = p;
  endtask

  task automatic run_prog(input string tag);
    logic [DW-1:0] ea, epc;
    int ecyc;
    int guard;
    ref_run(ea, epc, ecyc);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state is the first fetch step
    chk("R1", {tag, " reset strobes"},
        {buf_load, sub_mode, acc_load, acc_drive, const_drive, const_one,
         pc_drive, pc_load, pc_step, mem_write, port_drive, mem_drive,
         addr_load, instr_load, clk_hold}, 32'h104);
    rst = 1'b0;
    @(negedge clk);
    // R2: second fetch step
    chk("R2", {tag, " fetch step 2"},
        {buf_load, sub_mode, acc_load, acc_drive, const_drive, const_one,
         pc_drive, pc_load, pc_step, mem_write, port_drive, mem_drive,
         addr_load, instr_load, clk_hold}, 32'h4A);
    guard = 0;
    while (!(clk_hold && ir == 3'd7 && int'(pc) == last_addr + 1) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk("R10", {tag, " reached final halt"}, guard < 3000, 1);
    chk("R3", {tag, " accumulator"}, acc, ea);
    chk("R5", {tag, " final pc"}, pc, epc);
    chk("R5", {tag, " clock count"}, applied, ecyc);
    for (int i = 0; i < NDATA; i++)
      chk("R6", {tag, " data word"}, mem[DBASE+i], rmem[DBASE+i]);
  endtask

  task automatic clear_img();
    for (int i = 0; i < MEMN; i++) img[i] = '0;
    for (int i = 0; i < NDATA; i++) img[DBASE+i] = DW'($urandom);
    for (int i = 0; i < NIN; i++) in_vals[i] = DW'($urandom);
  endtask

  task automatic build_random();
    logic [2:0] ops [20];
    int starts [21];
    int n, a, r, j;
    clear_img();
    n = 4 + int'($urandom % 12);
    a = 0;
    for (int i = 0; i < n; i++) begin
      r = int'($urandom % 16);
      if (r < 2)       ops[i] = 3'd0;
      else if (r < 4)  ops[i] = 3'd1;
      else if (r < 6)  ops[i] = 3'd2;
      else if (r < 8)  ops[i] = 3'd3;
      else if (r < 11) ops[i] = 3'd4;
      else if (r < 13) ops[i] = 3'd5;
      else if (r < 15) ops[i] = 3'd6;
      else             ops[i] = 3'd7;
      starts[i] = a;
      a += (ops[i] <= 3'd4) ? 2 : 1;
    end
    starts[n] = a;
    last_addr = a;
    for (int i = 0; i < n; i++) begin
      img[starts[i]] = DW'(ops[i]);
      if (ops[i] == 3'd4) begin
        j = i + 1 + int'($urandom % (n - i));
        img[starts[i]+1] = DW'(starts[j]);
      end else if (ops[i] <= 3'd3)
        img[starts[i]+1] = DW'(DBASE + int'($urandom % NDATA));
    end
    img[a] = DW'(7);
  endtask

  // watchdog
  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    wait_tgt = 2;

    // Directed 1 (R8, R3, R6): three inputs summed through memory
    clear_img();
    img[0] = 8'd5; img[1] = 8'd3; img[2] = 8'd200; img[3] = 8'd5;
    img[4] = 8'd3; img[5] = 8'd201; img[6] = 8'd5; img[7] = 8'd1;
    img[8] = 8'd200; img[9] = 8'd1; img[10] = 8'd201; img[11] = 8'd7;
    last_addr = 11;
    run_prog("R8 inputs");

    // Directed 2 (R4, R7 taken): subtract to zero, jump, wrap below zero
    clear_img();
    img[DBASE] = 8'd9; img[DBASE+1] = 8'd9; img[DBASE+2] = 8'd77;
    img[0] = 8'd0; img[1] = 8'd200; img[2] = 8'd2; img[3] = 8'd201;
    img[4] = 8'd4; img[5] = 8'd8; img[6] = 8'd0; img[7] = 8'd202;
    img[8] = 8'd3; img[9] = 8'd203; img[10] = 8'd6; img[11] = 8'd2;
    img[12] = 8'd200; img[13] = 8'd7;
    last_addr = 13;
    run_prog("R4 R7 taken");
    chk("R4", "wrap result", acc, 8'd247);
    chk("R7", "taken jump skipped load", mem[DBASE+3], 8'd0);

    // Directed 3 (R7 not taken, R9, R10 mid halt)
    clear_img();
    img[DBASE] = 8'd5; img[DBASE+1] = 8'd99;
    img[0] = 8'd0; img[1] = 8'd200; img[2] = 8'd4; img[3] = 8'd8;
    img[4] = 8'd7; img[5] = 8'd6; img[6] = 8'd3; img[7] = 8'd201;
    img[8] = 8'd1; img[9] = 8'd200; img[10] = 8'd7;
    last_addr = 10;
    run_prog("R9 R10 mid halt");
    chk("R9", "clear then store", mem[DBASE+1], 8'd0);
    chk("R7", "not taken result", acc, 8'd5);

    // Random programs with run noise while the clock is free (R12)
    noise_en = 1;
    for (int t = 0; t < 40; t++) begin
      build_random();
      run_prog("R12 random");
    end

    chk("R11", "bus conflict cycles", conflicts, 0);
    chk("R4", "stray subtract cycles", sub_stray, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule